// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer and Refresh Scheduler

This block owns the SDRAM command pins from reset onward. It first holds the bus deselected for a settling pause whose length comes from the clock frequency. It then walks the device through its start-up ritual: a precharge of all banks, a fixed train of auto-refresh commands, and a load of the mode register. After the mode-load delay it raises `init_done`. From then on it issues periodic refreshes, each as a precharge-all followed by an auto-refresh. The gap between refreshes is a count that software supplies.

The geometry, CAS latency, row timing and refresh period are plain configuration inputs, expected to be held stable. The block checks that the refresh period is not zero. A zero period raises `config_error` and the sequence does not begin. The block also reports the byte capacity of the attached device as a base-2 logarithm, derived from the column, row and bank selections and the bus width.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready handshake is involved.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command bus is deselected ({cs_n,ras_n,cas_n,we_n} = 1111) and `init_done` is low. The first command appears on the clock edge numbered PAUSE_CYC = CLK_MHZ*PAUSE_US after reset release, and no command appears before it.
- R2: The first command is Precharge All ({cs_n,ras_n,cas_n,we_n} = 0010) with address bit 10 high.
- R3: Exactly eight Auto Refresh commands (0001) follow. The first comes tRP cycles after the precharge, and each later one comes tRC cycles after the one before it. A timing input of zero acts as one cycle.
- R4: tRC cycles after the eighth refresh, one Load Mode command (0000) is issued. Its address carries the CAS latency in bits 6:4 and zero in bits 3:0, which selects burst length 1 and sequential ordering. The bank address is zero.
- R5: `init_done` rises exactly TMRD cycles after the Load Mode command and stays high until reset.
- R6: While `init_done` is low and the refresh period input is zero, `config_error` is high from the next cycle, and no command is issued. Once the period is nonzero, the sequence begins.
- R7: In normal operation, a Precharge All is issued P cycles after `init_done` rises or after the previous refresh finishes, where P is the refresh period. An Auto Refresh follows tRP cycles later. The period count restarts tRC cycles after that refresh.
- R8: `size_log2` equals (col_sel+8)+(row_sel+11)+(bank_sel+1)+(half_bus ? 1 : 2). The device holds 2^size_log2 bytes.
- R9: On every cycle that carries no command, the bus shows deselect (1111).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_col_sel | input | 2 | Column address bits minus 8 |
| cfg_row_sel | input | 2 | Row address bits minus 11 |
| cfg_bank_sel | input | 1 | Bank address bits minus 1 |
| cfg_half_bus | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| cfg_cas_lat | input | 3 | CAS latency written into the mode register |
| cfg_t_rp | input | TW | Precharge-to-next-command gap in cycles |
| cfg_t_rc | input | TW | Refresh-to-next-command gap in cycles |
| cfg_ref_period | input | RPW | Cycles between periodic refreshes; zero is illegal |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BAW | Bank address |
| sd_addr | output | AW | Address bus |
| init_done | output | 1 | Start-up sequence complete |
| config_error | output | 1 | Refresh period of zero seen during start-up |
| size_log2 | output | 6 | Log2 of device capacity in bytes |

## Verification
The embedded assertions check on every cycle that each precharge carries A10, that the delay and refresh counters never wrap below zero, that an expired refresh count stays latched until it is serviced, and that `init_done` is sticky and never coexists with `config_error`. The exact command order, the cycle-accurate spacing set by tRP, tRC, TMRD and the refresh period, the mode address contents, and the resume after a zero period is corrected can only be shown by the bench's timed scenarios. The same holds for the derived size.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_MRS   = 4'b0000
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_PAUSE,
    S_W_PRE,
    S_W_REF,
    S_W_MRS,
    S_NORM,
    S_W_RPRE,
    S_W_RREF
  } seq_st_e;

endpackage

// File: rtl/sdinit_delay.sv
module sdinit_delay #(
  parameter int unsigned W       = 4,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);

  // R3
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdinit_refresh_timer.sv
module sdinit_refresh_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         reload,
  input  logic [W-1:0] period,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (reload)            cnt <= (period == '0) ? '0 : period - 1'b1;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = run && (cnt == '0);

  // R7
  req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !reload) |=> (cnt == '0));

endmodule

// File: rtl/sdinit_geom.sv
module sdinit_geom (
  input  logic [1:0] col_sel,
  input  logic [1:0] row_sel,
  input  logic       bank_sel,
  input  logic       half_bus,
  output logic [5:0] size_log2
);
  always_comb begin
    size_log2 = 6'(col_sel) + 6'd8 + 6'(row_sel) + 6'd11 + 6'(bank_sel) + 6'd1
              + (half_bus ? 6'd1 : 6'd2);
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 200,
  parameter int unsigned PAUSE_US = 200,
  parameter int unsigned TW       = 4,
  parameter int unsigned RPW      = 16,
  parameter int unsigned TMRD     = 3,
  parameter int unsigned NREF     = 8,
  parameter int unsigned AW       = 13,
  parameter int unsigned BAW      = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_col_sel,
  input  logic [1:0]     cfg_row_sel,
  input  logic           cfg_bank_sel,
  input  logic           cfg_half_bus,
  input  logic [2:0]     cfg_cas_lat,
  input  logic [TW-1:0]  cfg_t_rp,
  input  logic [TW-1:0]  cfg_t_rc,
  input  logic [RPW-1:0] cfg_ref_period,
  output logic           sd_cs_n,
  output logic           sd_ras_n,
  output logic           sd_cas_n,
  output logic           sd_we_n,
  output logic [BAW-1:0] sd_ba,
  output logic [AW-1:0]  sd_addr,
  output logic           init_done,
  output logic           config_error,
  output logic [5:0]     size_log2
);
  localparam int unsigned PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int unsigned PW        = $clog2(PAUSE_CYC + 1);
  localparam int unsigned RCW       = $clog2(NREF + 1);
  localparam logic [TW-1:0] MRD_GAP = TW'(TMRD - 1);

  function automatic logic [TW-1:0] gap_of(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  seq_st_e        st, nxt_st;
  sd_cmd_e        cmd_q, nxt_cmd;
  logic [AW-1:0]  addr_q, nxt_addr;
  logic [RCW-1:0] ref_cnt;
  logic           done_q, nxt_done, err_q;
  logic           gap_load, gap_zero, pause_zero;
  logic [TW-1:0]  gap_val;
  logic           tmr_reload, tmr_expired;
  logic           ref_first, ref_inc;
  logic           period_ok;

  assign period_ok = (cfg_ref_period != '0);

  sdinit_delay #(.W(PW), .RST_VAL(PAUSE_CYC - 1)) u_pause (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .zero(pause_zero)
  );

  sdinit_delay #(.W(TW), .RST_VAL(0)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  sdinit_refresh_timer #(.W(RPW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(st == S_NORM), .reload(tmr_reload),
    .period(cfg_ref_period), .expired(tmr_expired)
  );

  sdinit_geom u_geom (
    .col_sel(cfg_col_sel), .row_sel(cfg_row_sel), .bank_sel(cfg_bank_sel),
    .half_bus(cfg_half_bus), .size_log2(size_log2)
  );

  always_comb begin
    nxt_st     = st;
    nxt_cmd    = CMD_DESEL;
    nxt_addr   = '0;
    nxt_done   = done_q;
    gap_load   = 1'b0;
    gap_val    = '0;
    tmr_reload = 1'b0;
    ref_first  = 1'b0;
    ref_inc    = 1'b0;
    case (st)
      S_PAUSE: if (pause_zero && period_ok) begin
        nxt_cmd      = CMD_PRE;
        nxt_addr[10] = 1'b1;
        gap_load     = 1'b1;
        gap_val      = gap_of(cfg_t_rp);
        nxt_st       = S_W_PRE;
      end
      S_W_PRE: if (gap_zero) begin
        nxt_cmd   = CMD_REF;
        gap_load  = 1'b1;
        gap_val   = gap_of(cfg_t_rc);
        ref_first = 1'b1;
        nxt_st    = S_W_REF;
      end
      S_W_REF: if (gap_zero) begin
        gap_load = 1'b1;
        if (ref_cnt == RCW'(NREF)) begin
          nxt_cmd       = CMD_MRS;
          nxt_addr[6:4] = cfg_cas_lat;
          gap_val       = MRD_GAP;
          nxt_st        = S_W_MRS;
        end else begin
          nxt_cmd = CMD_REF;
          gap_val = gap_of(cfg_t_rc);
          ref_inc = 1'b1;
        end
      end
      S_W_MRS: if (gap_zero) begin
        nxt_done   = 1'b1;
        tmr_reload = 1'b1;
        nxt_st     = S_NORM;
      end
      S_NORM: if (tmr_expired) begin
        nxt_cmd      = CMD_PRE;
        nxt_addr[10] = 1'b1;
        gap_load     = 1'b1;
        gap_val      = gap_of(cfg_t_rp);
        nxt_st       = S_W_RPRE;
      end
      S_W_RPRE: if (gap_zero) begin
        nxt_cmd  = CMD_REF;
        gap_load = 1'b1;
        gap_val  = gap_of(cfg_t_rc);
        nxt_st   = S_W_RREF;
      end
      S_W_RREF: if (gap_zero) begin
        tmr_reload = 1'b1;
        nxt_st     = S_NORM;
      end
      default: nxt_st = S_PAUSE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_PAUSE;
      cmd_q   <= CMD_DESEL;
      addr_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ref_cnt <= '0;
    end else begin
      st     <= nxt_st;
      cmd_q  <= nxt_cmd;
      addr_q <= nxt_addr;
      done_q <= nxt_done;
      err_q  <= !done_q && !period_ok;
      if (ref_first)    ref_cnt <= RCW'(1);
      else if (ref_inc) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr      = addr_q;
  assign sd_ba        = '0;
  assign init_done    = done_q;
  assign config_error = err_q;

  // R2
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PRE) |-> sd_addr[10]);

  // R4
  mrs_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |-> !init_done);

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R6
  err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_error |-> !init_done);

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
  localparam int PAUSE = 20;
  localparam int TMRD  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] col_sel, row_sel;
  logic bank_sel, half_bus;
  logic [2:0] cas;
  logic [3:0] trp, trc;
  logic [15:0] per;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [12:0] addr;
  logic done, err;
  logic [5:0] sz;

  always #2.5 clk = ~clk;

  sdram_init_seq #(.CLK_MHZ(1), .PAUSE_US(PAUSE), .TMRD(TMRD)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_col_sel(col_sel), .cfg_row_sel(row_sel),
    .cfg_bank_sel(bank_sel), .cfg_half_bus(half_bus), .cfg_cas_lat(cas),
    .cfg_t_rp(trp), .cfg_t_rc(trc), .cfg_ref_period(per),
    .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
    .sd_ba(ba), .sd_addr(addr), .init_done(done), .config_error(err), .size_log2(sz)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_ev;
  int done_cyc;
  int bad_idle;
  logic [3:0]  ev_code [0:31];
  logic [12:0] ev_addr [0:31];
  logic [1:0]  ev_ba   [0:31];
  int          ev_cyc  [0:31];

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      n_ev = 0; done_cyc = -1; bad_idle = 0;
    end else begin
      if (!cs_n) begin
        if (n_ev < 32) begin
          ev_code[n_ev] = {cs_n, ras_n, cas_n, we_n};
          ev_addr[n_ev] = addr;
          ev_ba[n_ev]   = ba;
          ev_cyc[n_ev]  = cyc;
        end
        n_ev++;
      end else if ({ras_n, cas_n, we_n} != 3'b111) bad_idle++;
      if (done && done_cyc < 0) done_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int gp(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  // cas3 trp4 trc4 per16 col2 row2 bank1 half1 size6
  localparam logic [38:0] VEC [4] = '{
    {3'd2, 4'd2,  4'd6,  16'd40, 2'd1, 2'd2, 1'b1, 1'b1, 6'd25},
    {3'd3, 4'd3,  4'd7,  16'd25, 2'd0, 2'd0, 1'b0, 1'b0, 6'd22},
    {3'd1, 4'd0,  4'd1,  16'd10, 2'd2, 2'd1, 1'b1, 1'b0, 6'd26},
    {3'd3, 4'd15, 4'd15, 16'd1,  2'd3, 2'd2, 1'b1, 1'b1, 6'd27}
  };

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] exp_sz;
    {cas, trp, trc, per, col_sel, row_sel, bank_sel, half_bus, exp_sz} = VEC[0];
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(cs_n && ras_n && cas_n && we_n, "R1 reset bus", {cs_n,ras_n,cas_n,we_n}, 15);
    chk(!done, "R1 reset done", done, 0);

    for (int i = 0; i < 4; i++) begin
      int w;
      {cas, trp, trc, per, col_sel, row_sel, bank_sel, half_bus, exp_sz} = VEC[i];
      do_reset();
      w = 0;
      while (n_ev < 13 && w < 2000) begin @(negedge clk); w++; end
      chk(ev_cyc[0] == PAUSE, "R1 pause", ev_cyc[0], PAUSE);
      chk(ev_code[0] == 4'b0010 && ev_addr[0][10], "R2 first precharge",
          {ev_code[0], ev_addr[0][10]}, 5'b00101);
      for (int k = 1; k <= 8; k++) begin
        int sp;
        sp = (k == 1) ? gp(int'(trp)) : gp(int'(trc));
        chk(ev_code[k] == 4'b0001, "R3 refresh code", ev_code[k], 1);
        chk(ev_cyc[k] - ev_cyc[k-1] == sp, "R3 refresh gap", ev_cyc[k] - ev_cyc[k-1], sp);
      end
      chk(ev_code[9] == 4'b0000, "R4 mode code", ev_code[9], 0);
      chk(ev_addr[9][6:0] == {cas, 4'b0000} && ev_ba[9] == 2'b00, "R4 mode addr",
          ev_addr[9][6:0], {cas, 4'b0000});
      chk(ev_cyc[9] - ev_cyc[8] == gp(int'(trc)), "R4 mode gap", ev_cyc[9] - ev_cyc[8], gp(int'(trc)));
      chk(done_cyc - ev_cyc[9] == TMRD, "R5 done delay", done_cyc - ev_cyc[9], TMRD);
      chk(done, "R5 done held", done, 1);
      chk(ev_code[10] == 4'b0010 && ev_addr[10][10], "R7 refresh precharge", ev_code[10], 2);
      chk(ev_cyc[10] - done_cyc == int'(per), "R7 period", ev_cyc[10] - done_cyc, per);
      chk(ev_code[11] == 4'b0001, "R7 refresh cmd", ev_code[11], 1);
      chk(ev_cyc[11] - ev_cyc[10] == gp(int'(trp)), "R7 trp gap", ev_cyc[11] - ev_cyc[10], gp(int'(trp)));
      chk(ev_cyc[12] - ev_cyc[11] == gp(int'(trc)) + int'(per), "R7 reload",
          ev_cyc[12] - ev_cyc[11], gp(int'(trc)) + int'(per));
      chk(sz == exp_sz, "R8 size", sz, exp_sz);
      chk(bad_idle == 0, "R9 idle deselect", bad_idle, 0);
      chk(!err, "R6 no error", err, 0);
    end

    // R6 zero period blocks start-up, then resumes
    {cas, trp, trc, per, col_sel, row_sel, bank_sel, half_bus, exp_sz} = VEC[1];
    per = 16'd0;
    do_reset();
    repeat (60) @(negedge clk);
    chk(err, "R6 error flag", err, 1);
    chk(n_ev == 0, "R6 no command", n_ev, 0);
    chk(!done, "R6 not done", done, 0);
    per = 16'd30;
    begin
      int w;
      w = 0;
      while (n_ev < 1 && w < 100) begin @(negedge clk); w++; end
    end
    chk(n_ev >= 1 && ev_code[0] == 4'b0010, "R6 resume", n_ev, 1);
    chk(!err, "R6 error clears", err, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule